// File: doc/BRIEF.md
# Dual-Order Four-Beat Burst Offset Generator

This block produces the two least-significant address bits of a four-beat burst access, one offset per advanced beat. A load strobe captures a 2-bit starting offset together with the burst order chosen on the mode pin. Each advance then moves to the next beat. In incrementing order the offset is the start plus the beat number, wrapping modulo four. In interleaved order the offset is the start XORed with the beat number. After the fourth beat the next advance lands on the loaded start again.

The upper address bits, the storage array and any bus protocol belong to the surrounding logic, which adds this offset to its own base address. The interface carries no data stream, so there is no valid/ready handshake. Load and advance are plain single-cycle strobes, and the surrounding logic never has to wait on the block. The mode pin is meant to be tied high, or left at its default, for interleaved order. Only a solid low selects incrementing order.

Top module: `burst_ofs_gen`

## Requirements
- R1: After synchronous reset, `ofs_o` is 0, `beat_o` is 0 and `last_o` is 0.
- R2: A load (`load_i` high at a clock edge) makes `beat_o` 0 and `ofs_o` equal to the captured `start_i` from the next cycle on.
- R3: With `mode_i` low at load (incrementing order), `ofs_o` equals (`start` + `beat_o`) modulo 4 on every beat, e.g. start 1 gives 1, 2, 3, 0.
- R4: With `mode_i` high at load (interleaved order), `ofs_o` equals `start` XOR `beat_o` on every beat, e.g. start 1 gives 1, 0, 3, 2.
- R5: `beat_o` increases by one, modulo 4, on each edge where `adv_i` is high and `load_i` is low. It holds its value when both are low.
- R6: `last_o` is high exactly while `beat_o` equals 3.
- R7: The advance taken from beat 3 returns `beat_o` to 0 and `ofs_o` to the loaded start.
- R8: When `load_i` and `adv_i` are high in the same cycle, the load wins: the next beat is 0 and the offset is the new start.
- R9: The order is sampled only at load. A change on `mode_i` in the middle of a burst leaves the offset sequence unchanged until the next load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Capture start offset and order; beat restarts at 0 |
| start_i | input | 2 | Starting offset of the burst |
| adv_i | input | 1 | Advance to the next beat |
| mode_i | input | 1 | Order select at load: low incrementing, high (default) interleaved |
| ofs_o | output | 2 | Current burst offset |
| beat_o | output | 2 | Current beat index, 0 to 3 |
| last_o | output | 1 | High on the fourth beat |

## Verification
On every cycle, the assertions check how the beat counter steps, holds and restarts. They also check that the last-beat flag tracks beat 3, that the offset equals the new start right after a load and on wrap, and that the held order does not move between loads. Which arithmetic produces each offset in each order (the incrementing and XOR sequences for every start), load winning over advance, and immunity to a mid-burst mode change are shown only by the bench's scenarios against independently computed sequences.

// File: rtl/burst_ofs_pkg.sv
package burst_ofs_pkg;
  localparam int unsigned OFS_W = 2;
  localparam int unsigned BEATS = 1 << OFS_W;

  typedef enum logic {
    ORD_INCR = 1'b0,
    ORD_XOR  = 1'b1
  } order_e;

  typedef logic [OFS_W-1:0] ofs_t;
endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
  import burst_ofs_pkg::*;
(
  input  logic clk_i,
  input  logic rst_i,
  input  logic load_i,
  input  logic adv_i,
  output ofs_t beat_o,
  output logic last_o
);
  localparam ofs_t LAST_BEAT = ofs_t'(BEATS - 1);

  ofs_t beat_q, beat_d;
  logic last_q;

  always_comb begin
    beat_d = beat_q;
    if (load_i)     beat_d = '0;
    else if (adv_i) beat_d = beat_q + ofs_t'(1);
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      beat_q <= '0;
      last_q <= 1'b0;
    end else begin
      beat_q <= beat_d;
      last_q <= (beat_d == LAST_BEAT);
    end
  end

  assign beat_o = beat_q;
  assign last_o = last_q;

  a_r5_hold: assert property (@(posedge clk_i) disable iff (rst_i)
    (!load_i && !adv_i) |=> $stable(beat_q));
  a_r5_step: assert property (@(posedge clk_i) disable iff (rst_i)
    (!load_i && adv_i) |=> (beat_q == ofs_t'($past(beat_q) + ofs_t'(1))));
  a_r8_load_restart: assert property (@(posedge clk_i) disable iff (rst_i)
    load_i |=> (beat_q == '0));
  a_r6_last_flag: assert property (@(posedge clk_i) disable iff (rst_i)
    last_q == (beat_q == LAST_BEAT));
endmodule

// File: rtl/burst_start_reg.sv
module burst_start_reg
  import burst_ofs_pkg::*;
#(
  parameter order_e RESET_ORDER = ORD_XOR
) (
  input  logic   clk_i,
  input  logic   rst_i,
  input  logic   load_i,
  input  ofs_t   start_i,
  input  logic   mode_i,
  output ofs_t   start_o,
  output order_e order_o
);
  ofs_t   start_q;
  order_e order_q, order_sel;

  // only a solid low picks incrementing order; anything else is interleaved
  always_comb begin
    if (mode_i == 1'b0) order_sel = ORD_INCR;
    else                order_sel = ORD_XOR;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      start_q <= '0;
      order_q <= RESET_ORDER;
    end else if (load_i) begin
      start_q <= start_i;
      order_q <= order_sel;
    end
  end

  assign start_o = start_q;
  assign order_o = order_q;

  a_r9_order_held: assert property (@(posedge clk_i) disable iff (rst_i)
    !load_i |=> ($stable(order_q) && $stable(start_q)));
endmodule

// File: rtl/burst_ofs_map.sv
module burst_ofs_map
  import burst_ofs_pkg::*;
(
  input  ofs_t   start_i,
  input  ofs_t   beat_i,
  input  order_e order_i,
  output ofs_t   ofs_o
);
  always_comb begin
    unique case (order_i)
      ORD_INCR: ofs_o = start_i + beat_i;
      ORD_XOR:  ofs_o = start_i ^ beat_i;
      default:  ofs_o = start_i ^ beat_i;
    endcase
  end
endmodule

// File: rtl/burst_ofs_gen.sv
module burst_ofs_gen
  import burst_ofs_pkg::*;
#(
  parameter order_e RESET_ORDER = ORD_XOR
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             load_i,
  input  logic [OFS_W-1:0] start_i,
  input  logic             adv_i,
  input  logic             mode_i,
  output logic [OFS_W-1:0] ofs_o,
  output logic [OFS_W-1:0] beat_o,
  output logic             last_o
);
  ofs_t   start_q, beat_q;
  order_e order_q;

  burst_start_reg #(.RESET_ORDER(RESET_ORDER)) u_start (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .load_i  (load_i),
    .start_i (start_i),
    .mode_i  (mode_i),
    .start_o (start_q),
    .order_o (order_q)
  );

  burst_beat_ctr u_beat (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .load_i (load_i),
    .adv_i  (adv_i),
    .beat_o (beat_q),
    .last_o (last_o)
  );

  burst_ofs_map u_map (
    .start_i (start_q),
    .beat_i  (beat_q),
    .order_i (order_q),
    .ofs_o   (ofs_o)
  );

  assign beat_o = beat_q;

  a_r2_load_ofs: assert property (@(posedge clk_i) disable iff (rst_i)
    load_i |=> (ofs_o == $past(start_i)));
  a_r7_wrap_to_start: assert property (@(posedge clk_i) disable iff (rst_i)
    (!load_i && adv_i && last_o) |=> (ofs_o == start_q && beat_o == '0));
endmodule

// File: tb/sim_burst_ofs_gen.sv
`timescale 1ns/1ps
module sim_burst_ofs_gen;
  logic       clk = 1'b0;
  logic       rst, load, adv, mode;
  logic [1:0] start;
  logic [1:0] ofs, beat;
  logic       last;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  burst_ofs_gen u0 (
    .clk_i(clk), .rst_i(rst), .load_i(load), .start_i(start),
    .adv_i(adv), .mode_i(mode), .ofs_o(ofs), .beat_o(beat), .last_o(last)
  );

  function automatic logic [1:0] exp_ofs(input logic m, input logic [1:0] s, input logic [1:0] b);
    return m ? (s ^ b) : 2'(s + b);
  endfunction

  task automatic chk(input string req, input logic [1:0] eo, input logic [1:0] eb, input logic el);
    n_chk++;
    if (ofs !== eo || beat !== eb || last !== el) begin
      n_bad++;
      $display("FAIL %s: ofs/beat/last got %0d/%0d/%0b exp %0d/%0d/%0b", req, ofs, beat, last, eo, eb, el);
    end
  endtask

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic do_load(input logic [1:0] s, input logic m);
    load = 1'b1; adv = 1'b0; start = s; mode = m;
    tick();
    load = 1'b0;
  endtask

  // R3 / R4 / R6 / R7: full burst plus wrap
  task automatic run_burst(input string req, input logic [1:0] s, input logic m);
    do_load(s, m);
    chk({req, " R2 after load"}, s, 2'd0, 1'b0);
    for (int i = 1; i <= 4; i++) begin
      adv = 1'b1; tick();
      chk({req, (i == 4) ? " R7 wrap" : " R6 beat"}, exp_ofs(m, s, 2'(i)), 2'(i), (i == 3));
    end
    adv = 1'b0;
  endtask

  task automatic t_reset;
    rst = 1'b1; load = 1'b0; adv = 1'b0; start = 2'd0; mode = 1'b1;
    tick(); tick();
    rst = 1'b0;
    chk("R1 reset", 2'd0, 2'd0, 1'b0);
  endtask

  task automatic t_hold;
    do_load(2'd2, 1'b0);
    adv = 1'b1; tick();
    adv = 1'b0; tick(); tick();
    chk("R5 hold without advance", 2'd3, 2'd1, 1'b0);
  endtask

  task automatic t_priority;
    do_load(2'd1, 1'b1);
    adv = 1'b1; tick(); tick();
    load = 1'b1; start = 2'd3; mode = 1'b0; tick();
    load = 1'b0; adv = 1'b0;
    chk("R8 load beats advance", 2'd3, 2'd0, 1'b0);
    adv = 1'b1; tick(); adv = 1'b0;
    chk("R8 new order incrementing", 2'd0, 2'd1, 1'b0);
  endtask

  task automatic t_mode_change;
    do_load(2'd2, 1'b1);
    for (int i = 1; i <= 3; i++) begin
      mode = ~mode; adv = 1'b1; tick();
      chk("R9 mode change ignored", exp_ofs(1'b1, 2'd2, 2'(i)), 2'(i), (i == 3));
    end
    adv = 1'b0;
  endtask

  initial begin
    t_reset();
    run_burst("R3 incr s1", 2'd1, 1'b0);
    run_burst("R3 incr s2", 2'd2, 1'b0);
    run_burst("R4 xor s1", 2'd1, 1'b1);
    run_burst("R4 xor s3", 2'd3, 1'b1);
    t_hold();
    t_priority();
    t_mode_change();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule